// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

The block produces four independent pulse-width-modulated outputs. Each channel has its own settings, written over a simple single-cycle register bus: an enable bit, an output sense bit, a 10-bit tick divider, a 16-bit period and a 16-bit active time. A channel counts ticks of the work clock divided by its divider. Its waveform repeats every `period` ticks. The output is in its active phase for the first `duty` ticks of each period.

Bus and waveform logic share one clock. Software is expected to clear a channel's enable bit before it changes that channel's timing, then set it again. Setting the enable bit starts the waveform at the beginning of a period. The sense bit has an inverted meaning: when set, the output is high during the active phase. When clear, every level on that output is inverted, including the idle level.

Top module: `pwm_quad`

## Requirements
- R1: After reset, every register reads as zero and all channels are disabled. Because the sense bit is clear, every `pwm_o` bit sits at 1.
- R2: Channel n (0..3) owns the byte offsets (n+1)*0x10 + {0x0 control, 0x4 period, 0x8 duty}. The control register has enable at bit 0, sense at bit 1 and the divider at bits 11:2. Period and duty occupy bits 15:0. Reads return the last value written, and bits outside these fields read as zero.
- R3: The following accesses are unmapped: offsets 0x00–0x0F, offset +0xC inside a bank, offsets at or above 0x50, and any address with bits 1:0 not zero. Unmapped reads return zero and unmapped writes change no register.
- R4: While enable is 0, a channel's counters are held at zero and its output is at the idle level: 0 when sense is 1, and 1 when sense is 0.
- R5: With sense = 1, the output is high during the active phase. With sense = 0, the output is the bitwise inverse of that waveform.
- R6: The tick counter advances once every `div` bus clocks. In sample i after enabling (i = 0 is the first cycle), the active phase holds when (i / div) mod period < duty.
- R7: A divider value of 0 behaves exactly like 1.
- R8: If duty = 0, the output is never active. If duty >= period, the output is always active.
- R9: Clearing enable and then setting it again restarts the waveform at sample 0 of a period.
- R10: Channels are independent. Register writes to one channel do not disturb the waveform of another.
- R11: Read data appears on `rdata_o` in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and work clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| pwm_o | output | 4 | One PWM output per channel |

## Verification
On every cycle, the assertions check the following:
- counters return to zero while a channel is idle and when it is re-enabled;
- the tick counter moves only by one step or wraps;
- unmapped reads return zero;
- configuration never changes without a write;
- a channel whose duty covers its period stays in its active level.

Only the bench scenarios can show the remaining behaviour, because it depends on the exact sequence over many cycles. This covers the cycle-exact waveform shape for each divider, period and duty combination, inverted sense, a zero divider, the restart phase after re-enabling, and independence between channels.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int DIV_W = 10;
  localparam int CNT_W = 16;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic             en;
    logic             pol;
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] duty;
  } chan_cfg_t;

  typedef enum logic [1:0] {
    W_CTRL   = 2'd0,
    W_PERIOD = 2'd1,
    W_DUTY   = 2'd2,
    W_NONE   = 2'd3
  } word_e;
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output chan_cfg_t [NCH-1:0]   cfg_o
);
  localparam int BANK_W = ADDR_W - 4;
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NCH);
  localparam int CTRL_W = DIV_W + 2;

  logic [BANK_W-1:0] bank, idx;
  word_e             word;
  logic              hit;
  logic [DATA_W-1:0] rd_val;
  chan_cfg_t [NCH-1:0] cfg_q;

  assign bank = addr_i[ADDR_W-1:4];
  assign idx  = bank - BANK_W'(1);
  assign word = word_e'(addr_i[3:2]);
  assign hit  = (addr_i[1:0] == 2'b00) && (bank != '0) && (bank <= LAST_BANK)
                && (word != W_NONE);

  for (genvar c = 0; c < NCH; c++) begin : g_bank
    logic sel_wr;
    assign sel_wr = req_i && we_i && hit && (idx == BANK_W'(c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[c] <= '0;
      end else if (sel_wr) begin
        case (word)
          W_CTRL: begin
            cfg_q[c].en  <= wdata_i[0];
            cfg_q[c].pol <= wdata_i[1];
            cfg_q[c].div <= wdata_i[CTRL_W-1:2];
          end
          W_PERIOD: cfg_q[c].period <= wdata_i[CNT_W-1:0];
          W_DUTY:   cfg_q[c].duty   <= wdata_i[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_val = '0;
    for (int c = 0; c < NCH; c++) begin
      if (hit && idx == BANK_W'(c)) begin
        case (word)
          W_CTRL:   rd_val = DATA_W'({cfg_q[c].div, cfg_q[c].pol, cfg_q[c].en});
          W_PERIOD: rd_val = DATA_W'(cfg_q[c].period);
          W_DUTY:   rd_val = DATA_W'(cfg_q[c].duty);
          default:  rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_o <= '0;
    else if (req_i && !we_i)   rdata_o <= rd_val;
  end

  assign cfg_o = cfg_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:CTRL_W];

  a_r3_unmapped_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !hit) |=> (rdata_o == '0));

  a_r2_cfg_held_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(cfg_q));
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
  import pwm_quad_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  chan_cfg_t cfg_i,
  output logic      pwm_o
);
  logic [DIV_W-1:0] pre_q, div_eff;
  logic [CNT_W-1:0] cnt_q;
  logic             tick, wrap, act;

  // zero divider behaves like one
  assign div_eff = (cfg_i.div == '0) ? DIV_W'(1) : cfg_i.div;
  assign tick    = pre_q >= (div_eff - DIV_W'(1));
  assign wrap    = (cfg_i.period <= CNT_W'(1)) || (cnt_q >= cfg_i.period - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!cfg_i.en) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
    end else begin
      pre_q <= pre_q + DIV_W'(1);
    end
  end

  assign act   = (cfg_i.duty != '0) && ((cfg_i.duty >= cfg_i.period) || (cnt_q < cfg_i.duty));
  assign pwm_o = cfg_i.en ? (cfg_i.pol ? act : !act) : !cfg_i.pol;

  a_r4_idle_counters_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |=> (cnt_q == '0 && pre_q == '0));

  a_r9_restart_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_i.en) |-> (cnt_q == '0 && pre_q == '0));

  a_r6_cnt_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && $past(cfg_i.en)) |->
      (cnt_q == '0 || cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));

  a_r8_full_duty_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && cfg_i.duty != '0 && cfg_i.duty >= cfg_i.period) |-> (pwm_o == cfg_i.pol));
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NCH-1:0]    pwm_o
);
  chan_cfg_t [NCH-1:0] cfg;

  pwm_quad_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .cfg_o   (cfg)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwm_quad_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cfg_i  (cfg[c]),
      .pwm_o  (pwm_o[c])
    );
  end
endmodule

// File: tb/pwm_quad_bench.sv
`timescale 1ns/1ps
module pwm_quad_bench;
  logic        clk = 0, rst_ni = 0, req = 0, we = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_quad u_pwm_quad (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req = 1; we = 0; addr = a;
    @(posedge clk); @(negedge clk);
    req = 0;
    d = rdata;
  endtask

  function automatic logic [7:0] base(input int ch);
    return 8'((ch + 1) * 16);
  endfunction

  function automatic logic [31:0] ctrl(input bit en, input bit pol, input int div);
    return {20'd0, 10'(div), pol, en};
  endfunction

  // program timing disabled, then enable; samples start right after the enable edge
  task automatic run_wave(input int ch, input int div, input int per, input int duty,
                          input bit pol, input int ncyc, input string tag);
    int bad = 0, first_bad = -1;
    int div_e = (div == 0) ? 1 : div;
    wr(base(ch), ctrl(0, pol, div));
    wr(base(ch) + 4, per);
    wr(base(ch) + 8, duty);
    wr(base(ch), ctrl(1, pol, div));
    for (int i = 0; i < ncyc; i++) begin
      bit a = (duty != 0) && ((duty >= per) || (((i / div_e) % per) < duty));
      bit e = pol ? a : !a;
      if (pwm[ch] !== e) begin bad++; if (first_bad < 0) first_bad = i; end
      @(negedge clk);
    end
    chk(bad == 0, tag, bad, 0);
    if (bad != 0) $display("  first mismatch at sample %0d", first_bad);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(pwm === 4'hF, "R1 outputs idle after reset", pwm, 4'hF);
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 3; w++) begin
        rd(base(c) + 8'(w * 4), d);
        chk(d === 0, "R1 register zero after reset", d, 0);
      end
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    for (int c = 0; c < 4; c++) begin
      wr(base(c), 32'hFFFF_FFF0 | 32'(c << 4));
      wr(base(c) + 4, 32'hABCD_0000 | 32'(c * 257 + 100));
      wr(base(c) + 8, 32'h5A5A_0000 | 32'(c * 3 + 7));
    end
    for (int c = 0; c < 4; c++) begin
      rd(base(c), d);
      chk(d === 32'h0000_0FF0, "R2 control readback masked", d, 32'hFF0);
      rd(base(c) + 4, d);
      chk(d === 32'(c * 257 + 100), "R2 period readback", d, c * 257 + 100);
      rd(base(c) + 8, d);
      chk(d === 32'(c * 3 + 7), "R2 duty readback", d, c * 3 + 7);
    end
    rd(base(3), d);
    wr(base(3), 32'h0000_0006);
    rd(base(3), d);
    chk(d === 32'h6, "R2 control low bits", d, 6);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    logic [7:0] bad_a[5] = '{8'h00, 8'h0C, 8'h1C, 8'h50, 8'h11};
    wr(base(0) + 4, 32'h0000_1111);
    foreach (bad_a[k]) begin
      wr(bad_a[k], 32'hFFFF_FFFF);
      rd(bad_a[k], d);
      chk(d === 0, "R3 unmapped read zero", d, 0);
    end
    rd(base(0) + 4, d);
    chk(d === 32'h1111, "R3 unmapped writes ignored", d, 32'h1111);
    rd(base(0) + 1, d);
    chk(d === 0, "R3 misaligned read zero", d, 0);
  endtask

  task automatic t_read_latency();
    wr(base(2) + 8, 32'h0000_0BEE);
    req = 1; we = 0; addr = base(2) + 8;
    #1;
    chk(rdata !== 32'hBEE, "R11 no data before edge", rdata, 0);
    @(posedge clk); @(negedge clk);
    req = 0;
    chk(rdata === 32'hBEE, "R11 data one cycle after request", rdata, 32'hBEE);
  endtask

  task automatic t_disable();
    for (int c = 0; c < 4; c++) wr(base(c), ctrl(0, 1, 1));
    wr(base(1) + 4, 4); wr(base(1) + 8, 4);
    repeat (3) @(negedge clk);
    chk(pwm === 4'h0, "R4 idle level low with sense set", pwm, 0);
    wr(base(1), ctrl(0, 0, 1));
    @(negedge clk);
    chk(pwm[1] === 1'b1, "R4 idle level high with sense clear", pwm[1], 1);
  endtask

  task automatic t_waves();
    run_wave(1, 3, 5, 2, 1, 30, "R6 div3 per5 duty2 normal");
    wr(base(1), 0);
    run_wave(3, 2, 4, 1, 0, 24, "R5 inverted div2 per4 duty1");
    wr(base(3), 0);
    run_wave(2, 0, 3, 1, 1, 12, "R7 zero divider acts as one");
    run_wave(2, 1, 3, 1, 1, 12, "R7 reference divider one");
    run_wave(0, 1, 5, 0, 1, 12, "R8 duty zero never active");
    run_wave(0, 2, 5, 7, 1, 12, "R8 duty above period always active");
    run_wave(0, 1, 5, 5, 0, 12, "R8 duty equal period inverted");
  endtask

  task automatic t_restart();
    run_wave(0, 2, 6, 3, 1, 9, "R9 first run");
    wr(base(0), ctrl(0, 1, 2));
    run_wave(0, 2, 6, 3, 1, 24, "R9 restart from period start");
  endtask

  task automatic t_indep();
    int bad = 0;
    logic prev;
    wr(base(1), ctrl(0, 1, 1));
    run_wave(0, 1, 2, 1, 1, 2, "R10 setup ch0");
    wr(base(1) + 4, 9); wr(base(1) + 8, 3); wr(base(2), ctrl(0, 1, 5));
    prev = pwm[0];
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (pwm[0] === prev || pwm[1] !== 1'b0) bad++;
      prev = pwm[0];
    end
    chk(bad == 0, "R10 ch0 undisturbed by other channel writes", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_unmapped();
    t_read_latency();
    t_disable();
    t_waves();
    t_restart();
    t_indep();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule